// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar clock for a byte-wide peripheral bus. A 1 Hz tick input advances packed-BCD counters for seconds, minutes, hours, day of month, month, two-digit year and day of week. Month lengths follow the calendar, and February gets 29 days in years whose two BCD digits form a multiple of four. A bank of BCD alarm registers is compared against the date and time after every counting tick, and a full match latches an alarm flag. Second, minute, hour and day boundary flags are also latched. The interrupt-enable register routes either the alarm flag, one selected boundary flag, or both to a registered, level-sensitive interrupt line.

Software reads a consistent time by writing the control register with the snapshot bit set. That copies all seven live counters into a static latch set in one cycle. While the shadow-select control bit is set, reads of the time addresses return the latched copy. Counting is gated by an active-high run bit. Status flags are cleared by writing ones. The remaining control bits and the two compensation bytes are storage only.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, control reads 0x00, status reads 0x80 (power-up flag, bit 7), interrupt enable reads 0x00, the time reads 00:00:00 on day 0x01, month 0x01, year 0x00 and weekday 0x00, and irq is low.
- R2: Control bit 0 is the run bit. While it is 1, each tick_1hz pulse advances the seconds. While it is 0, ticks leave every counter unchanged. Status bit 1 reads back the run bit.
- R3: Seconds and minutes count 0x00 to 0x59 in BCD (0x09 is followed by 0x10). Hours count 0x00 to 0x23. Each wrap carries into the next field, and a wrap of the hours also advances the weekday, which counts 0 to 6 and then returns to 0.
- R4: The day counts from 0x01 up to the month length and then returns to 0x01, advancing the month. The month length is 30 for months 0x04, 0x06, 0x09 and 0x11, 29 or 28 for month 0x02 depending on whether the year is a multiple of four, and 31 for all other months.
- R5: Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R6: Byte writes load the time registers (seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06) and the alarm registers (0x07 to 0x0C in the same field order). Reads return the written values.
- R7: Writing control (0x0D) with bit 6 set copies all live counters into the shadow latches on that clock edge. Bit 6 always reads 0. While control bit 7 is 1, reads of 0x00 to 0x06 return the shadow copy; otherwise they return the live counters.
- R8: Status (0x0E) bits 2, 3, 4 and 5 are set when a counting tick ends a second, a minute, an hour and a day respectively.
- R9: Writing a 1 to status bits 2 to 7 clears those bits, writing 0 leaves them unchanged, and bits 1 and 0 are not writable.
- R10: When the time after a counting tick equals all six alarm fields, status bit 6 is set one cycle later and stays set until it is cleared by a write.
- R11: irq is registered and equals (status bit 6 AND enable bit 3) OR (selected boundary flag AND enable bit 2). Enable bits 1:0 select the boundary flag: 00 second, 01 minute, 10 hour, 11 day.
- R12: Control bits 0 to 5 and 7, enable bits 3:0 and the compensation bytes at 0x10 and 0x11 store and read back. Undecoded addresses read 0x00.
- R13: bus_rdata takes the addressed value on the clock edge where bus_rd is high and holds it while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W (5) | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check that a frozen clock does not move, that the seconds and day wraps return to their first value, that a snapshot equals the live time of the previous cycle, and that status clears, the sticky alarm, the interrupt path and the read-data hold behave as required. Calendar correctness across leap and non-leap Februaries, 30- and 31-day months and the year-99 wrap can only be shown by the bench's directed scenarios. The same applies to the exact status byte after a midnight rollover, to shadow-versus-live read selection, and to the choice of boundary flag through the period encoding.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int N_DATE    = 6;   // sec, min, hr, day, mon, yr
  localparam int OFS_TIME0 = 0;
  localparam int OFS_WDAY  = 6;
  localparam int OFS_ALM0  = 7;
  localparam int OFS_CTRL  = 13;
  localparam int OFS_STAT  = 14;
  localparam int OFS_IEN   = 15;
  localparam int OFS_CMPL  = 16;
  localparam int OFS_CMPH  = 17;

  // field i sits at bits [8i+7:8i], matching address order
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_date_t;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four on two BCD digits
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
#(
  parameter int NLD = N_DATE + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [NLD-1:0]  ld_sel,
  input  logic [7:0]      ld_val,
  output cal_date_t       now,
  output logic [7:0]      wday,
  output logic [3:0]      ev
);
  cal_date_t  t_q;
  logic [7:0] wk_q;
  logic [7:0] dim;
  logic       mon_ev, yr_ev;

  assign dim    = last_day(t_q.mon, t_q.yr);
  assign ev[0]  = adv;
  assign ev[1]  = adv   && (t_q.sec == 8'h59);
  assign ev[2]  = ev[1] && (t_q.min == 8'h59);
  assign ev[3]  = ev[2] && (t_q.hr  == 8'h23);
  assign mon_ev = ev[3] && (t_q.day == dim);
  assign yr_ev  = mon_ev && (t_q.mon == 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q  <= '{yr: 8'h00, mon: 8'h01, day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};
      wk_q <= 8'h00;
    end else begin
      if (ev[0]) t_q.sec <= ev[1] ? 8'h00 : bcd_step(t_q.sec);
      if (ev[1]) t_q.min <= ev[2] ? 8'h00 : bcd_step(t_q.min);
      if (ev[2]) t_q.hr  <= ev[3] ? 8'h00 : bcd_step(t_q.hr);
      if (ev[3]) begin
        t_q.day <= mon_ev ? 8'h01 : bcd_step(t_q.day);
        wk_q    <= (wk_q == 8'h06) ? 8'h00 : wk_q + 8'h01;
      end
      if (mon_ev) t_q.mon <= yr_ev ? 8'h01 : bcd_step(t_q.mon);
      if (yr_ev)  t_q.yr  <= (t_q.yr == 8'h99) ? 8'h00 : bcd_step(t_q.yr);
      // software loads take priority over counting
      if (ld_sel[0]) t_q.sec <= ld_val;
      if (ld_sel[1]) t_q.min <= ld_val;
      if (ld_sel[2]) t_q.hr  <= ld_val;
      if (ld_sel[3]) t_q.day <= ld_val;
      if (ld_sel[4]) t_q.mon <= ld_val;
      if (ld_sel[5]) t_q.yr  <= ld_val;
      if (ld_sel[NLD-1]) wk_q <= ld_val;
    end
  end

  assign now  = t_q;
  assign wday = wk_q;

  assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && ld_sel == '0) |=> ($stable(t_q) && $stable(wk_q)));
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ev[1] && ld_sel == '0) |=> (t_q.sec == 8'h00));
  assert_day_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (mon_ev && ld_sel == '0) |=> (t_q.day == 8'h01));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_pkg::*;
#(
  parameter int NF = N_DATE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] ld_sel,
  input  logic [7:0]    ld_val,
  input  logic [8*NF-1:0] live,
  output logic [8*NF-1:0] alm,
  output logic          hit
);
  logic [8*NF-1:0] al_q;
  logic [NF-1:0]   eq;

  always_ff @(posedge clk) begin
    if (rst) al_q <= '0;
    else begin
      for (int i = 0; i < NF; i++)
        if (ld_sel[i]) al_q[i*8 +: 8] <= ld_val;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign eq[g] = (live[g*8 +: 8] == al_q[g*8 +: 8]);
  end

  assign hit = &eq;
  assign alm = al_q;
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int NLD = N_DATE + 1;

  int          addr_i;
  logic [NLD-1:0]    t_ld;
  logic [N_DATE-1:0] a_ld;
  logic        ctrl_wr, stat_wr, adv, hit, alarm_set, ev_sel;
  cal_date_t   live, shadow_q, tsrc;
  logic [7:0]  wk, shadow_wk_q, tsrc_wk;
  logic [8*N_DATE-1:0] alm;
  logic [3:0]  ev;
  logic [7:0]  ctrl_q, cmpl_q, cmph_q, rd_val, rdata_q;
  logic [7:2]  stat_q;
  logic [3:0]  ien_q;
  logic        ticked_q, irq_q;

  assign addr_i  = int'(bus_addr);
  assign ctrl_wr = bus_wr && (addr_i == OFS_CTRL);
  assign stat_wr = bus_wr && (addr_i == OFS_STAT);
  assign adv     = tick_1hz && ctrl_q[0];

  for (genvar g = 0; g < N_DATE; g++) begin : g_ld
    assign t_ld[g] = bus_wr && (addr_i == OFS_TIME0 + g);
    assign a_ld[g] = bus_wr && (addr_i == OFS_ALM0 + g);
  end
  assign t_ld[NLD-1] = bus_wr && (addr_i == OFS_WDAY);

  cal_time_chain #(.NLD(NLD)) u_chain (
    .clk(clk), .rst(rst), .adv(adv), .ld_sel(t_ld), .ld_val(bus_wdata),
    .now(live), .wday(wk), .ev(ev)
  );

  cal_alarm_match #(.NF(N_DATE)) u_alarm (
    .clk(clk), .rst(rst), .ld_sel(a_ld), .ld_val(bus_wdata),
    .live(live), .alm(alm), .hit(hit)
  );

  assign alarm_set = ticked_q && hit;

  always_comb begin
    case (ien_q[1:0])
      2'd0:    ev_sel = stat_q[2];
      2'd1:    ev_sel = stat_q[3];
      2'd2:    ev_sel = stat_q[4];
      default: ev_sel = stat_q[5];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= 8'h00;
      stat_q      <= 6'b100000;
      ien_q       <= 4'h0;
      cmpl_q      <= 8'h00;
      cmph_q      <= 8'h00;
      shadow_q    <= '0;
      shadow_wk_q <= 8'h00;
      ticked_q    <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      ticked_q <= adv;
      if (ctrl_wr) begin
        ctrl_q <= bus_wdata & 8'hBF;
        if (bus_wdata[6]) begin
          shadow_q    <= live;
          shadow_wk_q <= wk;
        end
      end
      for (int j = 0; j < 4; j++)
        stat_q[j+2] <= ev[j] | (stat_q[j+2] & ~(stat_wr & bus_wdata[j+2]));
      stat_q[6] <= alarm_set | (stat_q[6] & ~(stat_wr & bus_wdata[6]));
      stat_q[7] <= stat_q[7] & ~(stat_wr & bus_wdata[7]);
      if (bus_wr && addr_i == OFS_IEN)  ien_q  <= bus_wdata[3:0];
      if (bus_wr && addr_i == OFS_CMPL) cmpl_q <= bus_wdata;
      if (bus_wr && addr_i == OFS_CMPH) cmph_q <= bus_wdata;
      irq_q <= (stat_q[6] & ien_q[3]) | (ev_sel & ien_q[2]);
    end
  end

  assign tsrc    = ctrl_q[7] ? shadow_q : live;
  assign tsrc_wk = ctrl_q[7] ? shadow_wk_q : wk;

  always_comb begin
    rd_val = 8'h00;
    if (addr_i < OFS_WDAY)
      rd_val = tsrc[addr_i*8 +: 8];
    else if (addr_i >= OFS_ALM0 && addr_i < OFS_ALM0 + N_DATE)
      rd_val = alm[(addr_i-OFS_ALM0)*8 +: 8];
    else begin
      case (addr_i)
        OFS_WDAY: rd_val = tsrc_wk;
        OFS_CTRL: rd_val = ctrl_q;
        OFS_STAT: rd_val = {stat_q, ctrl_q[0], 1'b0};
        OFS_IEN:  rd_val = {4'h0, ien_q};
        OFS_CMPL: rd_val = cmpl_q;
        OFS_CMPH: rd_val = cmph_q;
        default:  rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  assert_snapshot_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[6]) |=> (shadow_q == $past(live)));
  assert_pwr_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && bus_wdata[7]) |=> !stat_q[7]);
  assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (stat_q[6] && !(stat_wr && bus_wdata[6])) |=> stat_q[6]);
  assert_alarm_irq_R11: assert property (@(posedge clk) disable iff (rst)
    (stat_q[6] && ien_q[3]) |=> irq);
  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_rtc u_bcd_rtc (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // op: 0 write, 1 read and compare, 2 counting tick
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h0D, 8'h00, 8'd1}, '{2'd1, 8'h0E, 8'h80, 8'd1},   // R1 reset values
    '{2'd1, 8'h03, 8'h01, 8'd1}, '{2'd1, 8'h04, 8'h01, 8'd1},
    '{2'd1, 8'h00, 8'h00, 8'd1},
    '{2'd0, 8'h00, 8'h58, 8'd6}, '{2'd0, 8'h01, 8'h59, 8'd6},   // R6 loads
    '{2'd0, 8'h02, 8'h23, 8'd6}, '{2'd0, 8'h03, 8'h28, 8'd6},
    '{2'd0, 8'h04, 8'h02, 8'd6}, '{2'd0, 8'h05, 8'h23, 8'd6},
    '{2'd0, 8'h06, 8'h06, 8'd6}, '{2'd1, 8'h05, 8'h23, 8'd6},
    '{2'd1, 8'h06, 8'h06, 8'd6},
    '{2'd0, 8'h0D, 8'h01, 8'd2}, '{2'd1, 8'h0E, 8'h82, 8'd2},   // R2 run flag
    '{2'd2, 8'h00, 8'h00, 8'd2}, '{2'd1, 8'h00, 8'h59, 8'd2},
    '{2'd1, 8'h0E, 8'h86, 8'd8},                                // R8 second flag
    '{2'd0, 8'h0E, 8'hFC, 8'd9}, '{2'd1, 8'h0E, 8'h02, 8'd9},   // R9 clear all
    '{2'd2, 8'h00, 8'h00, 8'd3},                                // midnight, non-leap Feb 28
    '{2'd1, 8'h00, 8'h00, 8'd3}, '{2'd1, 8'h01, 8'h00, 8'd3},
    '{2'd1, 8'h02, 8'h00, 8'd3}, '{2'd1, 8'h03, 8'h01, 8'd4},
    '{2'd1, 8'h04, 8'h03, 8'd4}, '{2'd1, 8'h06, 8'h00, 8'd3},
    '{2'd1, 8'h05, 8'h23, 8'd5},
    '{2'd1, 8'h0E, 8'h3E, 8'd8},                                // R8 all four flags
    '{2'd0, 8'h0E, 8'h04, 8'd9}, '{2'd1, 8'h0E, 8'h3A, 8'd9},
    '{2'd0, 8'h0E, 8'h00, 8'd9}, '{2'd1, 8'h0E, 8'h3A, 8'd9},
    '{2'd0, 8'h10, 8'hA5, 8'd12}, '{2'd1, 8'h10, 8'hA5, 8'd12}, // R12 storage
    '{2'd0, 8'h11, 8'h5A, 8'd12}, '{2'd1, 8'h11, 8'h5A, 8'd12},
    '{2'd0, 8'h0F, 8'h0B, 8'd12}, '{2'd1, 8'h0F, 8'h0B, 8'd12},
    '{2'd0, 8'h0F, 8'h00, 8'd12},
    '{2'd0, 8'h0D, 8'h3F, 8'd12}, '{2'd1, 8'h0D, 8'h3F, 8'd12},
    '{2'd0, 8'h0D, 8'h01, 8'd12}, '{2'd1, 8'h15, 8'h00, 8'd12},
    '{2'd0, 8'h07, 8'h33, 8'd13}, '{2'd1, 8'h07, 8'h33, 8'd13}  // R13 read path
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a[4:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a[4:0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dd, input logic [7:0] mo, input logic [7:0] y);
    wr(8'h00, s); wr(8'h01, m); wr(8'h02, h);
    wr(8'h03, dd); wr(8'h04, mo); wr(8'h05, y);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: rdchk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].data);
        default: tick();
      endcase
    end

    // R3 BCD digit step and minute carry without hour carry
    set_time(8'h09, 8'h14, 8'h05, 8'h10, 8'h07, 8'h40);
    tick(); rdchk("R3 sec 09->10", 8'h00, 8'h10);
    wr(8'h00, 8'h59); tick();
    rdchk("R3 min carry", 8'h01, 8'h15);
    rdchk("R3 sec wrap", 8'h00, 8'h00);
    rdchk("R3 hour kept", 8'h02, 8'h05);

    // R4 leap February, 30-day and 31-day months
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    tick(); rdchk("R4 leap day 29", 8'h03, 8'h29); rdchk("R4 leap month", 8'h04, 8'h02);
    wr(8'h00, 8'h59); wr(8'h01, 8'h59); wr(8'h02, 8'h23);
    tick(); rdchk("R4 after Feb 29", 8'h03, 8'h01); rdchk("R4 March", 8'h04, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24);
    tick(); rdchk("R4 30-day month", 8'h03, 8'h01); rdchk("R4 May", 8'h04, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h24);
    tick(); rdchk("R4 31-day month", 8'h03, 8'h31);

    // R5 year end and century wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    tick();
    rdchk("R5 month wrap", 8'h04, 8'h01);
    rdchk("R5 year wrap", 8'h05, 8'h00);
    rdchk("R5 day", 8'h03, 8'h01);

    // R2 stopped clock ignores ticks
    wr(8'h0D, 8'h00); wr(8'h00, 8'h42);
    tick();
    rdchk("R2 frozen sec", 8'h00, 8'h42);
    rd(8'h0E, d); chk("R2 run flag low", d & 8'h02, 8'h00);

    // R7 snapshot and shadow selection
    wr(8'h0D, 8'h01); wr(8'h00, 8'h10);
    wr(8'h0D, 8'hC1);
    rdchk("R7 snap bit reads 0", 8'h0D, 8'h81);
    tick();
    rdchk("R7 shadow read", 8'h00, 8'h10);
    wr(8'h0D, 8'h01);
    rdchk("R7 live read", 8'h00, 8'h11);

    // R10 alarm match and R11 alarm interrupt
    wr(8'h0E, 8'hFC); wr(8'h0F, 8'h08);
    set_time(8'h09, 8'h00, 8'h12, 8'h15, 8'h06, 8'h30);
    wr(8'h07, 8'h10); wr(8'h08, 8'h00); wr(8'h09, 8'h12);
    wr(8'h0A, 8'h15); wr(8'h0B, 8'h06); wr(8'h0C, 8'h30);
    chk("R11 irq idle", {7'd0, irq}, 8'h00);
    tick();
    chk("R11 alarm irq", {7'd0, irq}, 8'h01);
    rd(8'h0E, d); chk("R10 alarm flag", d & 8'h40, 8'h40);
    tick();
    rd(8'h0E, d); chk("R10 alarm sticky", d & 8'h40, 8'h40);
    wr(8'h0E, 8'h40);
    rd(8'h0E, d); chk("R9 alarm cleared", d & 8'h40, 8'h00);
    chk("R11 irq dropped", {7'd0, irq}, 8'h00);

    // R11 timer interrupt on minute selection
    wr(8'h0E, 8'hFC); wr(8'h0F, 8'h05);
    wr(8'h00, 8'h20); tick();
    chk("R11 minute sel no irq", {7'd0, irq}, 8'h00);
    wr(8'h00, 8'h59); tick();
    chk("R11 minute sel irq", {7'd0, irq}, 8'h01);

    // R1 reset in mid-run
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rdchk("R1 status after reset", 8'h0E, 8'h80);
    rdchk("R1 enable after reset", 8'h0F, 8'h00);
    rdchk("R1 weekday after reset", 8'h06, 8'h00);

    finish_run();
  end
endmodule